// File: doc/BRIEF.md
# Indexed Multi-Socket Register Port

This block lets a host reach a large bank of per-socket byte registers through only two byte addresses. Offset 0 holds an 8-bit index register; offset 1 is a data window whose target is chosen by that index. The upper bits of the index choose a socket and the lower six bits choose one of that socket's 64 registers. A socket's registers therefore start at index `socket * 0x40`.

Writes and reads at offset 1 are passed straight to the chosen socket's register-file port. The block drives a shared register address, shared write data and a per-socket write strobe. It also drives a per-socket read strobe, so that registers which clear on read can react to the access. Read data returns combinationally in the same cycle. The index stays unchanged across data accesses, so a read-modify-write needs no second index write. A 16-bit value is carried as two byte accesses at consecutive indices, low byte first.

The number of sockets actually fitted is a parameter, at most four. Data accesses whose index selects a socket above that count are inert.

Top module: `idx_sock_port`

## Requirements
- R1: After reset the index register is 0x00, and a read at offset 0 returns 0x00.
- R2: A host write at offset 0 (host_addr=0) loads host_wdata into the index at the clock edge. Reads at offset 0 then return that value.
- R3: A host write at offset 1 pulses sk_wr_en for exactly one socket in the same cycle. That socket is index[7:6], sk_reg_addr equals index[5:0], and sk_wdata equals host_wdata.
- R4: A host read at offset 1 returns the selected socket's sk_rdata combinationally. In the same cycle it pulses sk_rd_en only for that socket.
- R5: Data-port accesses never change the index. A read followed by a write at offset 1 both target the same register without rewriting the index.
- R6: When index[7:6] is at or above NUM_SOCKETS, offset-1 reads return 0x00 and raise no read strobe, and offset-1 writes raise no write strobe.
- R7: Writing index N, low byte, index N+1, high byte stores the low byte at register N and the high byte at register N+1 of the same socket.
- R8: Accesses at offset 0 and idle cycles raise no socket strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 1 | 0 = index port, 1 = data port |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| sk_reg_addr | output | 6 | Register number within the selected socket |
| sk_wdata | output | 8 | Write data to sockets |
| sk_wr_en | output | NUM_SOCKETS | Per-socket write strobe |
| sk_rd_en | output | NUM_SOCKETS | Per-socket read strobe |
| sk_rdata | input | 8*NUM_SOCKETS | Read data from each socket, socket 0 in the low byte |

## Verification
The assertions assume the host never raises host_wr and host_rd in the same cycle. They also assume strobes last one cycle per access, so the one-hot and index-hold properties describe single accesses. The bench drives every access through tasks that raise exactly one strobe for one clock and then clear it. The bench uses a three-socket configuration so that socket field value 3 exercises the out-of-range path.

// File: rtl/idx_port_pkg.sv
package idx_port_pkg;
    localparam int IDX_W    = 8;
    localparam int DATA_W   = 8;
    localparam int REG_BITS = 6;
    localparam int SOCK_BITS = IDX_W - REG_BITS;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } idx_state_t;
endpackage

// File: rtl/idx_reg.sv
module idx_reg
    import idx_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] wdata,
    output logic [IDX_W-1:0] idx_q
);
    idx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.idx = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_q = st_q.idx;
endmodule

// File: rtl/idx_decode.sv
module idx_decode
    import idx_port_pkg::*;
#(
    parameter int NUM_SOCKETS = 4
) (
    input  logic [IDX_W-1:0]     idx,
    input  logic                 host_addr,
    input  logic                 host_wr,
    input  logic                 host_rd,
    output logic [SOCK_BITS-1:0] sel,
    output logic                 sel_valid,
    output logic [REG_BITS-1:0]  reg_addr,
    output logic [NUM_SOCKETS-1:0] wr_en,
    output logic [NUM_SOCKETS-1:0] rd_en
);
    logic data_wr, data_rd;

    assign sel       = idx[IDX_W-1 -: SOCK_BITS];
    assign reg_addr  = idx[REG_BITS-1:0];
    assign sel_valid = (int'(sel) < NUM_SOCKETS);
    assign data_wr   = host_addr & host_wr & sel_valid;
    assign data_rd   = host_addr & host_rd & sel_valid;

    for (genvar s = 0; s < NUM_SOCKETS; s++) begin : g_strobe
        assign wr_en[s] = data_wr & (sel == SOCK_BITS'(s));
        assign rd_en[s] = data_rd & (sel == SOCK_BITS'(s));
    end
endmodule

// File: rtl/rdata_mux.sv
module rdata_mux
    import idx_port_pkg::*;
#(
    parameter int NUM_SOCKETS = 4
) (
    input  logic                          host_addr,
    input  logic [IDX_W-1:0]              idx,
    input  logic [SOCK_BITS-1:0]          sel,
    input  logic                          sel_valid,
    input  logic [NUM_SOCKETS*DATA_W-1:0] sk_rdata,
    output logic [DATA_W-1:0]             host_rdata
);
    logic [DATA_W-1:0] sock_data;

    always_comb begin
        sock_data = '0;
        for (int s = 0; s < NUM_SOCKETS; s++) begin
            if (sel_valid && sel == SOCK_BITS'(s)) begin
                sock_data = sk_rdata[s*DATA_W +: DATA_W];
            end
        end
    end

    assign host_rdata = host_addr ? sock_data : DATA_W'(idx);
endmodule

// File: rtl/idx_sock_port.sv
module idx_sock_port
    import idx_port_pkg::*;
#(
    parameter int NUM_SOCKETS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          host_addr,
    input  logic                          host_wr,
    input  logic                          host_rd,
    input  logic [7:0]                    host_wdata,
    output logic [7:0]                    host_rdata,
    output logic [5:0]                    sk_reg_addr,
    output logic [7:0]                    sk_wdata,
    output logic [NUM_SOCKETS-1:0]        sk_wr_en,
    output logic [NUM_SOCKETS-1:0]        sk_rd_en,
    input  logic [NUM_SOCKETS*8-1:0]      sk_rdata
);
    logic [IDX_W-1:0]     idx_q;
    logic [SOCK_BITS-1:0] sel;
    logic                 sel_valid;

    idx_reg u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (host_wr & ~host_addr),
        .wdata (host_wdata),
        .idx_q (idx_q)
    );

    idx_decode #(.NUM_SOCKETS(NUM_SOCKETS)) u_dec (
        .idx       (idx_q),
        .host_addr (host_addr),
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .sel       (sel),
        .sel_valid (sel_valid),
        .reg_addr  (sk_reg_addr),
        .wr_en     (sk_wr_en),
        .rd_en     (sk_rd_en)
    );

    rdata_mux #(.NUM_SOCKETS(NUM_SOCKETS)) u_mux (
        .host_addr  (host_addr),
        .idx        (idx_q),
        .sel        (sel),
        .sel_valid  (sel_valid),
        .sk_rdata   (sk_rdata),
        .host_rdata (host_rdata)
    );

    assign sk_wdata = host_wdata;
endmodule

// File: rtl/idx_port_chk.sv
module idx_port_chk #(
    parameter int NUM_SOCKETS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   host_addr,
    input logic                   host_wr,
    input logic                   host_rd,
    input logic [7:0]             host_wdata,
    input logic [7:0]             host_rdata,
    input logic [5:0]             sk_reg_addr,
    input logic [NUM_SOCKETS-1:0] sk_wr_en,
    input logic [NUM_SOCKETS-1:0] sk_rd_en,
    input logic [7:0]             idx_q
);
    logic oor;
    assign oor = (int'(idx_q[7:6]) >= NUM_SOCKETS);

    AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_addr) |=> (idx_q == $past(host_wdata))); // R2
    AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sk_wr_en)); // R3
    AST_WR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (|sk_wr_en) |-> (sk_reg_addr == idx_q[5:0])); // R3
    AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sk_rd_en)); // R4
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr && (host_wr || host_rd)) |=> $stable(idx_q)); // R5
    AST_OOR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        oor |-> (sk_wr_en == '0 && sk_rd_en == '0)); // R6
    AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr && oor) |-> (host_rdata == 8'h00)); // R6
    AST_IDX_NOSTROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !host_addr |-> (sk_wr_en == '0 && sk_rd_en == '0)); // R8
endmodule

bind idx_sock_port idx_port_chk #(.NUM_SOCKETS(NUM_SOCKETS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_addr   (host_addr),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .sk_reg_addr (sk_reg_addr),
    .sk_wr_en    (sk_wr_en),
    .sk_rd_en    (sk_rd_en),
    .idx_q       (idx_q)
);

// File: tb/tb_idx_sock_port.sv
module tb_idx_sock_port;
    localparam int NS = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           host_addr = 1'b0;
    logic           host_wr = 1'b0;
    logic           host_rd = 1'b0;
    logic [7:0]     host_wdata = '0;
    logic [7:0]     host_rdata;
    logic [5:0]     sk_reg_addr;
    logic [7:0]     sk_wdata;
    logic [NS-1:0]  sk_wr_en;
    logic [NS-1:0]  sk_rd_en;
    logic [NS*8-1:0] sk_rdata;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] mem [NS][64];
    int wr_cnt [NS];
    int rd_cnt [NS];

    always #4 clk = ~clk;

    idx_sock_port #(.NUM_SOCKETS(NS)) dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .sk_reg_addr(sk_reg_addr), .sk_wdata(sk_wdata), .sk_wr_en(sk_wr_en),
        .sk_rd_en(sk_rd_en), .sk_rdata(sk_rdata)
    );

    // socket register-file model
    always_comb begin
        for (int s = 0; s < NS; s++) sk_rdata[s*8 +: 8] = mem[s][sk_reg_addr];
    end

    always @(posedge clk) begin
        for (int s = 0; s < NS; s++) begin
            if (sk_wr_en[s]) begin
                mem[s][sk_reg_addr] <= sk_wdata;
                wr_cnt[s] <= wr_cnt[s] + 1;
            end
            if (sk_rd_en[s]) rd_cnt[s] <= rd_cnt[s] + 1;
        end
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic hw(logic a, logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hr(logic a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #2 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    function automatic int total(ref int c [NS]);
        int t = 0;
        for (int s = 0; s < NS; s++) t += c[s];
        return t;
    endfunction

    task automatic t_reset();
        logic [7:0] d;
        hr(1'b0, d);
        chk("R1 index after reset", d, 8'h00);
        chk("R8 no strobes after idle", total(wr_cnt) + total(rd_cnt), 0);
    endtask

    task automatic t_index();
        logic [7:0] d;
        hw(1'b0, 8'h85);
        hr(1'b0, d);
        chk("R2 index readback", d, 8'h85);
        hw(1'b0, 8'h3C);
        hr(1'b0, d);
        chk("R2 index reload", d, 8'h3C);
        chk("R8 index port raises no strobes", total(wr_cnt) + total(rd_cnt), 0);
    endtask

    task automatic t_wr_rd();
        logic [7:0] d;
        int r0;
        for (int s = 0; s < NS; s++) begin
            hw(1'b0, 8'((s << 6) | (5 + s)));
            hw(1'b1, 8'(8'hA0 + s));
            chk("R3 socket register written", mem[s][5 + s], 8'hA0 + s);
            chk("R3 write strobe count", wr_cnt[s], 1);
        end
        for (int s = 0; s < NS; s++) begin
            r0 = rd_cnt[s];
            hw(1'b0, 8'((s << 6) | (5 + s)));
            hr(1'b1, d);
            chk("R4 data read", d, 8'hA0 + s);
            chk("R4 read strobe on selected socket", rd_cnt[s], r0 + 1);
        end
        chk("R4 read strobes total", total(rd_cnt), NS);
    endtask

    task automatic t_rmw();
        logic [7:0] d;
        hw(1'b0, 8'h47);
        hw(1'b1, 8'h21);
        hr(1'b1, d);
        hw(1'b1, d | 8'h80);
        chk("R5 rmw result", mem[1][7], 8'hA1);
        hr(1'b0, d);
        chk("R5 index unchanged by data access", d, 8'h47);
    endtask

    task automatic t_word16();
        hw(1'b0, 8'h8A);
        hw(1'b1, 8'hEF);
        hw(1'b0, 8'h8B);
        hw(1'b1, 8'hBE);
        chk("R7 low byte at N", mem[2][10], 8'hEF);
        chk("R7 high byte at N+1", mem[2][11], 8'hBE);
    endtask

    task automatic t_oor();
        logic [7:0] d;
        int w0, r0;
        logic [7:0] keep;
        keep = mem[0][3];
        w0 = total(wr_cnt);
        r0 = total(rd_cnt);
        hw(1'b0, 8'hC3);
        hw(1'b1, 8'h55);
        hr(1'b1, d);
        chk("R6 out-of-range read is zero", d, 8'h00);
        chk("R6 no write strobe", total(wr_cnt), w0);
        chk("R6 no read strobe", total(rd_cnt), r0);
        chk("R6 no alias into socket 0", mem[0][3], keep);
    endtask

    initial begin
        for (int s = 0; s < NS; s++) begin
            wr_cnt[s] = 0; rd_cnt[s] = 0;
            for (int r = 0; r < 64; r++) mem[s][r] = 8'(s * 16 + r);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_index();
        t_wr_rd();
        t_rmw();
        t_word16();
        t_oor();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule